// File: doc/BRIEF.md
# Privilege-Gated Hypervisor Control Register

This block holds a 32-bit set of virtualization controls and serves it through a coprocessor-style move interface. Each request carries an encoding tuple (coprocessor number, two opcode fields, two register-number fields), a direction, write data, and the requester's context: its exception level (0 to 3) and its non-secure flag. Two side inputs tell the block whether level 2 is enabled and whether the external per-register trap bit is set. For each request that selects this register, the block gives a registered response one cycle later: the access completed, the access is undefined, or the access traps to the hypervisor with an 8-bit syndrome.

The block also exports a set of effective control values. These follow the stored bits, except in two cases. While the general-exception trap control is set, the three interrupt routing overrides are forced on. While the default-cacheability control is set, the stage-2 enable is forced on. A direct read always returns the stored bits and never the forced ones. Reserved bit positions hold zero whatever is written to them.

Top module: `hcr_ctrl_reg`

## Requirements
- R1: The register is selected only when coproc=4'b1111, opc1=3'b100, CRn=4'b0001, CRm=4'b0001 and opc2=3'b000. Any other request gives no response (`rsp_valid` stays 0) and does not change the register.
- R2: A selected request from level 0 gives response code 1 (undefined), whatever the direction.
- R3: A selected request from level 1 gives response code 2 (trap) with syndrome 8'h03 when `el2_enabled` and `trap_t1` are both 1. Otherwise it gives code 1. The syndrome is 0 on every response other than a trap.
- R4: A selected request from level 2 gives code 0 (ok). A read returns the stored value and a write stores `req_wdata`.
- R5: A selected request from level 3 gives code 0 when `req_ns` is 1 and code 1 when `req_ns` is 0.
- R6: Bits 31 and 28 always read as zero. Bit 29 also reads as zero when parameter HAVE_TOP_LEVEL is 0 (the default is 1, where bit 29 is writable).
- R7: After reset every stored bit and every effective bit is zero.
- R8: When stored bit 27 is 1, effective bits 5, 4 and 3 are 1. A direct read still returns the stored values of bits 5, 4 and 3.
- R9: When stored bit 12 is 1, effective bit 0 is 1. A direct read still returns the stored bit 0.
- R10: A write whose response code is not 0 leaves the stored and effective values unchanged.
- R11: The response, and for a completed read the data, appear on the first clock edge after the request. `rsp_rdata` is zero unless the response is a completed read. The effective outputs reflect a completed write on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Requester exception level |
| req_ns | input | 1 | Requester non-secure flag |
| req_coproc | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| el2_enabled | input | 1 | Level 2 enabled in the current state |
| trap_t1 | input | 1 | External per-register trap bit |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 ok, 1 undefined, 2 trap |
| rsp_syndrome | output | 8 | Trap syndrome, 0 unless trap |
| rsp_rdata | output | 32 | Read data for a completed read |
| eff_ctrl | output | 32 | Effective control values |

## Verification
A completed write and the change in the forced effective controls fall on the same clock edge. The bench provokes this with a single write that sets the general-exception trap or default-cacheability bit while the overrides or the stage-2 enable are written as zero. It judges the result by reading `eff_ctrl` on the response cycle and then reading the register back to see the stored zeros. A write followed at once by a read in the next cycle is also driven back to back, and the read must return the just-written value with no stall.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int unsigned CW = 32;
  localparam int unsigned SYW = 8;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_UNDEF = 2'd1,
    RSP_TRAP  = 2'd2
  } rsp_e;

  typedef struct packed {
    logic [3:0] cp;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } enc_t;

  localparam enc_t SEL_ENC = '{cp: 4'b1111, op1: 3'b100, crn: 4'b0001, crm: 4'b0001, op2: 3'b000};
  localparam logic [SYW-1:0] TRAP_SYND = 8'h03;

  localparam int unsigned B_RSV_HI  = 31;
  localparam int unsigned B_HVCDIS  = 29;
  localparam int unsigned B_RSV_LO  = 28;
  localparam int unsigned B_GETRAP  = 27;
  localparam int unsigned B_DEFCACH = 12;
  localparam int unsigned B_SERR_OV = 5;
  localparam int unsigned B_IRQ_OV  = 4;
  localparam int unsigned B_FIQ_OV  = 3;
  localparam int unsigned B_S2EN    = 0;
endpackage

// File: rtl/hcr_access_gate.sv
module hcr_access_gate
  import hcr_pkg::*;
#(
  parameter enc_t MATCH_ENC = SEL_ENC,
  parameter int unsigned SYND_W = SYW,
  parameter logic [SYND_W-1:0] SYND_VAL = TRAP_SYND
) (
  input  logic              valid,
  input  enc_t              enc,
  input  logic [1:0]        el,
  input  logic              ns,
  input  logic              el2_en,
  input  logic              t1,
  output logic              hit,
  output rsp_e              outcome,
  output logic [SYND_W-1:0] synd
);
  always_comb begin
    hit = valid && (enc == MATCH_ENC);
    outcome = RSP_UNDEF;
    synd = '0;
    unique case (el)
      2'd0: outcome = RSP_UNDEF;
      2'd1: begin
        if (el2_en && t1) begin
          outcome = RSP_TRAP;
          synd = SYND_VAL;
        end else begin
          outcome = RSP_UNDEF;
        end
      end
      2'd2: outcome = RSP_OK;
      default: outcome = ns ? RSP_OK : RSP_UNDEF;
    endcase
  end
endmodule

// File: rtl/hcr_store.sv
module hcr_store #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  always_comb begin
    d = q;
    if (wr_en) d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/hcr_effective.sv
module hcr_effective
  import hcr_pkg::*;
#(
  parameter int unsigned W = CW
) (
  input  logic [W-1:0] stored,
  output logic [W-1:0] eff
);
  localparam int unsigned NOV = 3;
  localparam int unsigned OV_POS [NOV] = '{B_SERR_OV, B_IRQ_OV, B_FIQ_OV};

  logic [W-1:0] force_bits;

  always_comb begin
    force_bits = '0;
    force_bits[B_S2EN] = stored[B_DEFCACH];
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ov_hit;
    always_comb begin
      ov_hit = 1'b0;
      for (int k = 0; k < NOV; k++) begin
        if (OV_POS[k] == i) ov_hit = 1'b1;
      end
    end
    assign eff[i] = stored[i] | force_bits[i] | (ov_hit & stored[B_GETRAP]);
  end
endmodule

// File: rtl/hcr_ctrl_reg.sv
module hcr_ctrl_reg
  import hcr_pkg::*;
#(
  parameter bit HAVE_TOP_LEVEL = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_el,
  input  logic            req_ns,
  input  logic [3:0]      req_coproc,
  input  logic [2:0]      req_opc1,
  input  logic [3:0]      req_crn,
  input  logic [3:0]      req_crm,
  input  logic [2:0]      req_opc2,
  input  logic [CW-1:0]   req_wdata,
  input  logic            el2_enabled,
  input  logic            trap_t1,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  output logic [SYW-1:0]  rsp_syndrome,
  output logic [CW-1:0]   rsp_rdata,
  output logic [CW-1:0]   eff_ctrl
);
  localparam logic [CW-1:0] RSV_ALWAYS = (CW'(1) << B_RSV_HI) | (CW'(1) << B_RSV_LO);
  localparam logic [CW-1:0] RSV_COND   = HAVE_TOP_LEVEL ? '0 : (CW'(1) << B_HVCDIS);
  localparam logic [CW-1:0] KEEP       = ~(RSV_ALWAYS | RSV_COND);

  enc_t            enc;
  logic            hit;
  rsp_e            outcome;
  logic [SYW-1:0]  synd;
  logic            do_wr;
  logic            do_rd;
  logic [CW-1:0]   stored_q;
  logic [CW-1:0]   stored_d;
  logic [CW-1:0]   eff_d;

  assign enc = '{cp: req_coproc, op1: req_opc1, crn: req_crn, crm: req_crm, op2: req_opc2};

  hcr_access_gate #(.MATCH_ENC(SEL_ENC), .SYND_W(SYW), .SYND_VAL(TRAP_SYND)) u_gate (
    .valid   (req_valid),
    .enc     (enc),
    .el      (req_el),
    .ns      (req_ns),
    .el2_en  (el2_enabled),
    .t1      (trap_t1),
    .hit     (hit),
    .outcome (outcome),
    .synd    (synd)
  );

  assign do_wr = hit && req_write  && (outcome == RSP_OK);
  assign do_rd = hit && !req_write && (outcome == RSP_OK);

  hcr_store #(.W(CW), .KEEP_MASK(KEEP)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (do_wr),
    .wdata (req_wdata),
    .q     (stored_q),
    .d     (stored_d)
  );

  hcr_effective #(.W(CW)) u_eff (
    .stored (stored_d),
    .eff    (eff_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= RSP_OK;
      rsp_syndrome <= '0;
      rsp_rdata    <= '0;
      eff_ctrl     <= '0;
    end else begin
      rsp_valid    <= hit;
      rsp_code     <= hit ? outcome : RSP_OK;
      rsp_syndrome <= hit ? synd : '0;
      rsp_rdata    <= do_rd ? stored_q : '0;
      eff_ctrl     <= eff_d;
    end
  end
endmodule

// File: rtl/hcr_ctrl_chk.sv
module hcr_ctrl_chk
  import hcr_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [1:0]      req_el,
  input logic            req_ns,
  input logic [3:0]      req_coproc,
  input logic [2:0]      req_opc1,
  input logic [3:0]      req_crn,
  input logic [3:0]      req_crm,
  input logic [2:0]      req_opc2,
  input logic [CW-1:0]   req_wdata,
  input logic            el2_enabled,
  input logic            trap_t1,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic [SYW-1:0]  rsp_syndrome,
  input logic [CW-1:0]   rsp_rdata,
  input logic [CW-1:0]   eff_ctrl
);
  logic sel;
  assign sel = req_valid && req_coproc == 4'b1111 && req_opc1 == 3'b100 &&
               req_crn == 4'b0001 && req_crm == 4'b0001 && req_opc2 == 3'b000;

  // R1
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !rsp_valid);

  // R2
  low_level_undef_chk: assert property (@(posedge clk) disable iff (rst)
    sel && req_el == 2'd0 |=> rsp_valid && rsp_code == 2'd1);

  // R3
  guest_trap_chk: assert property (@(posedge clk) disable iff (rst)
    sel && req_el == 2'd1 && el2_enabled && trap_t1 |=>
      rsp_code == 2'd2 && rsp_syndrome == 8'h03);

  // R5
  secure_top_undef_chk: assert property (@(posedge clk) disable iff (rst)
    sel && req_el == 2'd3 && !req_ns |=> rsp_code == 2'd1);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_rdata[31] == 1'b0 && rsp_rdata[28] == 1'b0);

  // R8
  override_force_chk: assert property (@(posedge clk) disable iff (rst)
    eff_ctrl[27] |-> eff_ctrl[5:3] == 3'b111);

  // R9
  stage2_force_chk: assert property (@(posedge clk) disable iff (rst)
    eff_ctrl[12] |-> eff_ctrl[0]);

  // R10
  refused_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_code != 2'd0 |-> $stable(eff_ctrl));

  // R11
  rdata_only_ok_read_chk: assert property (@(posedge clk) disable iff (rst)
    sel && (req_write || req_el == 2'd0) |=> rsp_rdata == '0);
endmodule

bind hcr_ctrl_reg hcr_ctrl_chk u_chk (.*);

// File: tb/tb_hcr_ctrl_reg.sv
module tb_hcr_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_el = 2'd0;
  logic        req_ns = 1'b1;
  logic [3:0]  req_coproc = 4'b1111;
  logic [2:0]  req_opc1 = 3'b100;
  logic [3:0]  req_crn = 4'b0001;
  logic [3:0]  req_crm = 4'b0001;
  logic [2:0]  req_opc2 = 3'b000;
  logic [31:0] req_wdata = '0;
  logic        el2_enabled = 1'b0;
  logic        trap_t1 = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [7:0]  rsp_syndrome;
  logic [31:0] rsp_rdata;
  logic [31:0] eff_ctrl;

  int total = 0;
  int bad = 0;
  logic        r_valid;
  logic [1:0]  r_code;
  logic [7:0]  r_synd;
  logic [31:0] r_data;
  logic [31:0] r_eff;

  always #2 clk = ~clk;

  hcr_ctrl_reg dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] el, input logic ns,
                        input logic e2, input logic t1, input logic match,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_el = el; req_ns = ns;
    el2_enabled = e2; trap_t1 = t1; req_wdata = wd;
    req_opc2 = match ? 3'b000 : 3'b001;
    @(negedge clk);
    r_valid = rsp_valid; r_code = rsp_code; r_synd = rsp_syndrome;
    r_data = rsp_rdata; r_eff = eff_ctrl;
    req_valid = 1'b0; req_opc2 = 3'b000;
  endtask

  task automatic rd2(output logic [31:0] v);
    access(1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, '0);
    v = r_data;
  endtask

  task automatic wr2(input logic [31:0] v);
    access(1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(eff_ctrl == 0, "R7 eff after reset", eff_ctrl, 0);
    rd2(v);
    chk(v == 0, "R7 stored after reset", v, 0);
    chk(r_valid && r_code == 2'd0, "R4 el2 read ok", {30'd0, r_code}, 0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    access(1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0F00);
    chk(!r_valid, "R1 no response off-encoding", {31'd0, r_valid}, 0);
    rd2(v);
    chk(v == 0, "R1 off-encoding write ignored", v, 0);
  endtask

  task automatic t_el2_rw;
    logic [31:0] v;
    wr2(32'h0123_4400);
    chk(r_valid && r_code == 2'd0 && r_synd == 0, "R4 el2 write ok", {22'd0, r_synd, r_code}, 0);
    chk(r_data == 0, "R11 no rdata on write", r_data, 0);
    chk(r_eff == 32'h0123_4400, "R11 eff on write edge", r_eff, 32'h0123_4400);
    rd2(v);
    chk(v == 32'h0123_4400, "R4 read back", v, 32'h0123_4400);
  endtask

  task automatic t_el0;
    logic [31:0] v;
    access(1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk(r_code == 2'd1 && r_data == 0, "R2 el0 read undef", {30'd0, r_code}, 1);
    access(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk(r_code == 2'd1, "R2 el0 write undef", {30'd0, r_code}, 1);
    rd2(v);
    chk(v == 32'h0123_4400, "R10 el0 write dropped", v, 32'h0123_4400);
  endtask

  task automatic t_el1;
    logic [31:0] v;
    access(1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0001);
    chk(r_code == 2'd2 && r_synd == 8'h03, "R3 trap", {22'd0, r_synd, r_code}, {22'd0, 8'h03, 2'd2});
    access(1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, '0);
    chk(r_code == 2'd1 && r_synd == 0, "R3 el2 off undef", {22'd0, r_synd, r_code}, 1);
    access(1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
    chk(r_code == 2'd1 && r_synd == 0, "R3 t1 clear undef", {22'd0, r_synd, r_code}, 1);
    rd2(v);
    chk(v == 32'h0123_4400, "R10 trapped write dropped", v, 32'h0123_4400);
  endtask

  task automatic t_el3;
    logic [31:0] v;
    access(1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_00C0);
    chk(r_code == 2'd1, "R5 secure el3 undef", {30'd0, r_code}, 1);
    rd2(v);
    chk(v == 32'h0123_4400, "R10 secure el3 write dropped", v, 32'h0123_4400);
    access(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_00C0);
    chk(r_code == 2'd0, "R5 ns el3 ok", {30'd0, r_code}, 0);
    access(1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, '0);
    chk(r_data == 32'h0000_00C0, "R5 ns el3 read", r_data, 32'h0000_00C0);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr2(32'hFFFF_FFFF);
    rd2(v);
    chk(v == 32'h6FFF_FFFF, "R6 reserved bits zero", v, 32'h6FFF_FFFF);
  endtask

  task automatic t_force;
    logic [31:0] v;
    wr2(32'h0800_0000);
    chk(r_eff == 32'h0800_0038, "R8 overrides forced", r_eff, 32'h0800_0038);
    rd2(v);
    chk(v == 32'h0800_0000, "R8 stored overrides", v, 32'h0800_0000);
    wr2(32'h0000_1000);
    chk(r_eff == 32'h0000_1001, "R9 stage2 forced", r_eff, 32'h0000_1001);
    rd2(v);
    chk(v == 32'h0000_1000, "R9 stored stage2", v, 32'h0000_1000);
    wr2(32'h0000_0010);
    chk(r_eff == 32'h0000_0010, "R8 no force when clear", r_eff, 32'h0000_0010);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_el = 2'd2; req_ns = 1'b1;
    req_wdata = 32'h0055_AA02;
    @(negedge clk);
    req_write = 1'b0; req_wdata = '0;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'h0055_AA02, "R11 back-to-back read", rsp_rdata, 32'h0055_AA02);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && rsp_rdata == 0, "R11 idle after read", rsp_rdata, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_select();
        t_el2_rw();
        t_el0();
        t_el1();
        t_el3();
        t_reserved();
        t_force();
        t_b2b();
      end
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule